// File: doc/BRIEF.md
# Sleep-Mode Power Sequencer

This block moves a device between full operation and a low-power sleep state. It runs from a free-running internal oscillator that never stops. It watches one external request pin. When the pin asks for sleep, the block first gates the global clock of the core domain. After a settle period it powers down the input buffers of every I/O bank and tri-states every output pin. When the pin releases the request, the steps run in reverse. The buffers come back first, a second settle period passes, and then the core clock is ungated. Core registers are never reset or cleared. The block only stops their clock, so their contents survive the sleep period.

Each I/O bank has one active-low input-buffer sleep line. Two of the banks share a single line, so the block drives one line fewer than there are banks, and line 0 serves the shared pair. Each output pin has its own output enable. Every control rests at 1 (awake, driving) out of reset. The request pin is asynchronous. It passes through a two-stage synchronizer and is then debounced before the sequencer acts on it. Two status outputs report the fully-asleep and fully-awake states. All pins are plain level controls. There is no data stream, so no valid/ready handshake applies.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: While reset is held and right after it, `core_clk_en` is 1, every bit of `bank_sleep_n` and `pin_oe` is 1, `is_awake` is 1 and `is_asleep` is 0.
- R2: `osc_en` reads 1 at every sampled cycle, whatever the sequencer state.
- R3: The synchronized pin level is accepted only once it has differed from the accepted level for DEBOUNCE_CYCLES consecutive clocks. A pulse shorter than that changes no output.
- R4: On the clock edge after a request is accepted in the awake state, `core_clk_en` falls to 0 while all buffer controls stay at 1.
- R5: The clock stays gated with buffers on for exactly ENTRY_SETTLE cycles. Then, if the request is still held, all `bank_sleep_n` and `pin_oe` bits go to 0 on the same edge.
- R6: One cycle after the buffers go down, `is_asleep` rises if the request is still held. While `is_asleep` is 1, the clock is gated and the buffers are down. `is_asleep` and `is_awake` are never 1 together.
- R7: On an accepted release while asleep, the buffer controls return to 1 first. `core_clk_en` returns to 1 exactly EXIT_SETTLE cycles later, and `is_awake` rises one cycle after that.
- R8: A request released during the clock-gate settle period still completes that period. The clock is then re-enabled and the buffer controls never leave 1.
- R9: A request released while the buffers are being powered down completes that step and then runs the full exit sequence of R7.
- R10: `core_clk_en` is never 1 in a cycle where any buffer control is 0.
- R11: `bank_sleep_n` is NUM_IO_BANKS-1 bits wide, with line 0 serving the shared bank pair. All `bank_sleep_n` and `pin_oe` bits always carry the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Free-running internal oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req_pin | input | 1 | Asynchronous sleep request; 1 asks for sleep, 0 asks for wake |
| osc_en | output | 1 | Oscillator enable, held at 1 |
| core_clk_en | output | 1 | Global clock gate enable for the core domain; 1 = clock runs |
| bank_sleep_n | output | NUM_IO_BANKS-1 | Active-low input-buffer sleep lines, one per bank (line 0 shared by two banks) |
| pin_oe | output | NUM_OE_PINS | Per-pin output enables; 0 tri-states the pin |
| is_asleep | output | 1 | 1 when fully asleep |
| is_awake | output | 1 | 1 when fully awake |

## Verification
A wrong sequencer state shows at the ports on the very next clock edge. Every output is a registered decode of that state, so a missed or extra transition flips `core_clk_en`, the buffer controls or a status bit one cycle off the reference model. A miscounted settle period shifts one of those edges by the same number of cycles. A debounce error makes an output move too early, too late, or on a pulse that should have been ignored. The per-cycle comparison therefore catches ordering faults, such as buffers dropping while the clock still runs, and timing faults at the first cycle where they differ.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;

  typedef enum logic [2:0] {
    PS_AWAKE    = 3'd0,
    PS_GATING   = 3'd1,
    PS_IO_DOWN  = 3'd2,
    PS_ASLEEP   = 3'd3,
    PS_IO_UP    = 3'd4,
    PS_UNGATING = 3'd5
  } pwr_state_e;

  // core clock runs only when no buffer can be down
  function automatic logic state_clk_on(input pwr_state_e s);
    return (s == PS_AWAKE) || (s == PS_UNGATING);
  endfunction

  function automatic logic state_bufs_on(input pwr_state_e s);
    return (s != PS_IO_DOWN) && (s != PS_ASLEEP);
  endfunction

endpackage

// File: rtl/sleep_req_filter.sv
module sleep_req_filter #(
  parameter int DEBOUNCE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic req_o
);
  localparam int CW = (DEBOUNCE_CYCLES > 1) ? $clog2(DEBOUNCE_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

  logic          sync_a, sync_b, req_q;
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a  <= 1'b0;
      sync_b  <= 1'b0;
      req_q   <= 1'b0;
      run_cnt <= '0;
    end else begin
      sync_a <= pin_async;
      sync_b <= sync_a;
      if (sync_b == req_q) begin
        run_cnt <= '0;
      end else if (run_cnt == LAST) begin
        req_q   <= sync_b;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
  import pwr_sleep_pkg::*;
#(
  parameter int ENTRY_SETTLE = 3,
  parameter int EXIT_SETTLE  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  output pwr_state_e state_next_o
);
  localparam int MAXS = (ENTRY_SETTLE > EXIT_SETTLE) ? ENTRY_SETTLE : EXIT_SETTLE;
  localparam int TW   = $clog2(MAXS + 1);
  localparam logic [TW-1:0] ENTRY_LAST = TW'(ENTRY_SETTLE - 1);
  localparam logic [TW-1:0] EXIT_LAST  = TW'(EXIT_SETTLE - 1);

  pwr_state_e    state_q, state_d;
  logic [TW-1:0] dwell_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PS_AWAKE:    if (req_i) state_d = PS_GATING;
      PS_GATING:   if (dwell_q == ENTRY_LAST) state_d = req_i ? PS_IO_DOWN : PS_UNGATING;
      PS_IO_DOWN:  state_d = req_i ? PS_ASLEEP : PS_IO_UP;
      PS_ASLEEP:   if (!req_i) state_d = PS_IO_UP;
      PS_IO_UP:    if (dwell_q == EXIT_LAST) state_d = PS_UNGATING;
      PS_UNGATING: state_d = PS_AWAKE;
      default:     state_d = PS_AWAKE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PS_AWAKE;
      dwell_q <= '0;
    end else begin
      state_q <= state_d;
      dwell_q <= (state_d != state_q) ? '0 : dwell_q + 1'b1;
    end
  end

  assign state_next_o = state_d;
endmodule

// File: rtl/pwr_ctrl_drive.sv
module pwr_ctrl_drive
  import pwr_sleep_pkg::*;
#(
  parameter int NUM_LINES = 7,
  parameter int NUM_OE    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  pwr_state_e           state_next_i,
  output logic                 clk_en_o,
  output logic [NUM_LINES-1:0] bank_n_o,
  output logic [NUM_OE-1:0]    oe_o,
  output logic                 asleep_o,
  output logic                 awake_o
);
  logic bufs_on_d;
  assign bufs_on_d = state_bufs_on(state_next_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_en_o <= 1'b1;
      asleep_o <= 1'b0;
      awake_o  <= 1'b1;
    end else begin
      clk_en_o <= state_clk_on(state_next_i);
      asleep_o <= (state_next_i == PS_ASLEEP);
      awake_o  <= (state_next_i == PS_AWAKE);
    end
  end

  for (genvar b = 0; b < NUM_LINES; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bank_n_o[b] <= 1'b1;
      else        bank_n_o[b] <= bufs_on_d;
    end
  end

  for (genvar p = 0; p < NUM_OE; p++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) oe_o[p] <= 1'b1;
      else        oe_o[p] <= bufs_on_d;
    end
  end
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
  import pwr_sleep_pkg::*;
#(
  parameter int NUM_IO_BANKS    = 8,
  parameter int NUM_OE_PINS     = 16,
  parameter int DEBOUNCE_CYCLES = 4,
  parameter int ENTRY_SETTLE    = 3,
  parameter int EXIT_SETTLE     = 5,
  localparam int NUM_BANK_LINES = NUM_IO_BANKS - 1
) (
  input  logic                      clk_osc,
  input  logic                      rst_n,
  input  logic                      sleep_req_pin,
  output logic                      osc_en,
  output logic                      core_clk_en,
  output logic [NUM_BANK_LINES-1:0] bank_sleep_n,
  output logic [NUM_OE_PINS-1:0]    pin_oe,
  output logic                      is_asleep,
  output logic                      is_awake
);
  logic       req_flt;
  pwr_state_e st_next;

  assign osc_en = 1'b1;

  sleep_req_filter #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_filter (
    .clk       (clk_osc),
    .rst_n     (rst_n),
    .pin_async (sleep_req_pin),
    .req_o     (req_flt)
  );

  sleep_seq_fsm #(.ENTRY_SETTLE(ENTRY_SETTLE), .EXIT_SETTLE(EXIT_SETTLE)) u_fsm (
    .clk          (clk_osc),
    .rst_n        (rst_n),
    .req_i        (req_flt),
    .state_next_o (st_next)
  );

  pwr_ctrl_drive #(.NUM_LINES(NUM_BANK_LINES), .NUM_OE(NUM_OE_PINS)) u_drive (
    .clk          (clk_osc),
    .rst_n        (rst_n),
    .state_next_i (st_next),
    .clk_en_o     (core_clk_en),
    .bank_n_o     (bank_sleep_n),
    .oe_o         (pin_oe),
    .asleep_o     (is_asleep),
    .awake_o      (is_awake)
  );
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk #(
  parameter int NUM_LINES = 1,
  parameter int NUM_OE    = 1
) (
  input logic                 clk_osc,
  input logic                 rst_n,
  input logic                 core_clk_en,
  input logic [NUM_LINES-1:0] bank_sleep_n,
  input logic [NUM_OE-1:0]    pin_oe,
  input logic                 is_asleep,
  input logic                 is_awake
);
  // R10
  gate_order_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    core_clk_en |-> ((&bank_sleep_n) && (&pin_oe)));

  // R11
  uniform_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (bank_sleep_n == {NUM_LINES{pin_oe[0]}}) && (pin_oe == {NUM_OE{pin_oe[0]}}));

  // R4
  entry_first_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $fell(core_clk_en) |-> ((&pin_oe) && (&bank_sleep_n)));

  // R5
  down_after_gate_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $fell(pin_oe[0]) |-> (!core_clk_en && $past(!core_clk_en)));

  // R7
  exit_order_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $rose(core_clk_en) |-> $past(&pin_oe));

  // R6
  asleep_chk: assert property (@(posedge clk_osc) disable iff (!rst_n)
    is_asleep |-> (!core_clk_en && !pin_oe[0] && !is_awake));
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk #(
  .NUM_LINES (NUM_BANK_LINES),
  .NUM_OE    (NUM_OE_PINS)
) u_chk (
  .clk_osc      (clk_osc),
  .rst_n        (rst_n),
  .core_clk_en  (core_clk_en),
  .bank_sleep_n (bank_sleep_n),
  .pin_oe       (pin_oe),
  .is_asleep    (is_asleep),
  .is_awake     (is_awake)
);

// File: tb/test_pwr_sleep_ctrl.sv
module test_pwr_sleep_ctrl;
  localparam int NB = 6;
  localparam int NL = NB - 1;
  localparam int NO = 4;
  localparam int DB = 3;
  localparam int ES = 6;
  localparam int XS = 5;

  // model states
  localparam int M_AWAKE = 0, M_GATE = 1, M_DOWN = 2, M_SLEEP = 3, M_UP = 4, M_UNGATE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic osc_en, core_clk_en, is_asleep, is_awake;
  logic [NL-1:0] bank_sleep_n;
  logic [NO-1:0] pin_oe;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int gate_aborts = 0;
  int down_aborts = 0;

  always #10 clk = ~clk;

  pwr_sleep_ctrl #(
    .NUM_IO_BANKS(NB), .NUM_OE_PINS(NO), .DEBOUNCE_CYCLES(DB),
    .ENTRY_SETTLE(ES), .EXIT_SETTLE(XS)
  ) i_pwr_sleep_ctrl (
    .clk_osc(clk), .rst_n(rst_n), .sleep_req_pin(pin), .osc_en(osc_en),
    .core_clk_en(core_clk_en), .bank_sleep_n(bank_sleep_n), .pin_oe(pin_oe),
    .is_asleep(is_asleep), .is_awake(is_awake)
  );

  // behavioural reference
  bit hist[$];
  bit m_req;
  int run;
  int st;
  int dwell;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{1'b0, 1'b0};
      m_req = 1'b0; run = 0; st = M_AWAKE; dwell = 0;
    end else begin
      int nx;
      bit d;
      nx = st;
      case (st)
        M_AWAKE:  if (m_req) nx = M_GATE;
        M_GATE:   if (dwell == ES - 1) nx = m_req ? M_DOWN : M_UNGATE;
        M_DOWN:   nx = m_req ? M_SLEEP : M_UP;
        M_SLEEP:  if (!m_req) nx = M_UP;
        M_UP:     if (dwell == XS - 1) nx = M_UNGATE;
        default:  nx = M_AWAKE;
      endcase
      if (st == M_GATE && nx == M_UNGATE) gate_aborts++;
      if (st == M_DOWN && nx == M_UP) down_aborts++;
      dwell = (nx != st) ? 0 : dwell + 1;
      st = nx;
      d = hist.pop_front();
      hist.push_back(pin);
      if (d == m_req) run = 0;
      else if (run == DB - 1) begin m_req = d; run = 0; end
      else run++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      bit ck, bo;
      ck = (st == M_AWAKE) || (st == M_UNGATE);
      bo = (st != M_DOWN) && (st != M_SLEEP);
      chk("R2 osc_en", 32'(osc_en), 32'd1);
      chk("R4/R7/R8 core_clk_en", 32'(core_clk_en), 32'(ck));
      chk("R5/R9/R11 bank_sleep_n", 32'(bank_sleep_n), 32'({NL{bo}}));
      chk("R5/R9/R11 pin_oe", 32'(pin_oe), 32'({NO{bo}}));
      chk("R6 is_asleep", 32'(is_asleep), 32'(st == M_SLEEP));
      chk("R7 is_awake", 32'(is_awake), 32'(st == M_AWAKE));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic hold(input bit lvl, input int n);
    pin = lvl;
    repeat (n) @(posedge clk);
    #3;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset clk_en", 32'(core_clk_en), 32'd1);
    chk("R1 reset oe", 32'(pin_oe), 32'({NO{1'b1}}));
    chk("R1 reset bank", 32'(bank_sleep_n), 32'({NL{1'b1}}));
    chk("R1 reset awake", 32'({is_awake, is_asleep}), 32'b10);
    @(posedge clk); #3;
    rst_n = 1'b1;
    hold(1'b0, 4);
    chk("R1 after reset awake", 32'({is_awake, core_clk_en, pin_oe[0]}), 32'b111);
    // short pulse below debounce length
    hold(1'b1, DB - 1);
    hold(1'b0, 12);
    chk("R3 glitch ignored", 32'({is_awake, core_clk_en, bank_sleep_n[0]}), 32'b111);
    // full entry and exit
    hold(1'b1, 30);
    chk("R6 asleep", 32'({is_asleep, core_clk_en, pin_oe[0]}), 32'b100);
    hold(1'b0, 30);
    chk("R7 awake again", 32'({is_awake, core_clk_en, pin_oe[0]}), 32'b111);
    // sweep request lengths to hit aborts at every step
    for (int n = 1; n <= 14; n++) begin
      hold(1'b1, n);
      hold(1'b0, 30);
      chk("R7 recovered", 32'(is_awake), 32'd1);
    end
    chk("R8 gating abort seen", 32'(gate_aborts > 0), 32'd1);
    chk("R9 io-down abort seen", 32'(down_aborts > 0), 32'd1);
    chk("R2 osc_en end", 32'(osc_en), 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule